// File: doc/BRIEF.md
# ADC Input Channel Sequencer

This block decides which analog inputs feed the sample/hold stage of an ADC front end for every sample/convert cycle. It holds two selection sets, A and B. Each set has a positive channel index and a negative-input choice. The negative-input choice picks either analog channel 1 or the low reference. A scan mask lists the channels that scan mode visits, and the remaining settings give an alternate-mode enable, a scan-mode enable and a burst length. The burst length is the number of samples taken between interrupts.

Each conversion-done strobe moves the sequencer to the next selection. In alternate mode, set A and set B take turns. In scan mode, set A's positive channel comes from the next enabled bit of the scan mask instead of from the set-A index, and set B is never scanned. When the last sample of a burst completes, the block raises a one-cycle interrupt pulse. At that point it reloads its configuration and starts the pattern again from set A and the lowest enabled scan channel.

The converter, the sample/hold amplifier, the result storage and any register access are outside this block. The configuration inputs are sampled only at burst boundaries and at reset.

Top module: `adc_chan_seq`

## Requirements
- R1: When set A is active and scan mode is off, `sel_pos` equals the set-A index captured at the last boundary. When set B is active, `sel_pos` equals the captured set-B index.
- R2: `sel_neg` equals the negative-input bit of the active set. A value of 1 means analog channel 1 and 0 means the low reference. In scan mode, set-A samples still use the set-A bit.
- R3: With alternate mode off, `sel_set_b` stays 0 for every sample.
- R4: With alternate mode on, the first sample after reset or after an interrupt uses set A (`sel_set_b`=0). Each later strobe in the burst toggles `sel_set_b`.
- R5: With scan mode on, set-A samples ignore the set-A index. They visit the enabled mask bits (bit n is channel n) in ascending order and wrap back to the lowest enabled bit when the list is used up. After each interrupt, scanning restarts at the lowest enabled bit.
- R6: With scan and alternate modes both on, samples go scan channel, set-B channel, next scan channel, and so on. Only set-A samples advance the scan position.
- R7: If the mask enables more channels than the burst has set-A samples, the higher-numbered enabled channels are never selected.
- R8: A burst-length field value n gives n+1 samples per burst. `irq_pulse` is high for exactly the one cycle after the clock edge that takes the strobe completing the last sample of the burst.
- R9: In scan mode with an all-zero mask, set-A samples select channel 0.
- R10: Configuration input changes do not affect the outputs until the next interrupt boundary or reset.
- R11: After a synchronous reset, set A is active, the scan position and sample count are cleared, and `irq_pulse` is 0. Strobes during reset are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| conv_done | input | 1 | Conversion-done strobe, one per completed sample |
| cfg_pos_a | input | IDX_W | Set-A positive channel index |
| cfg_neg_a | input | 1 | Set-A negative choice (1 = channel 1, 0 = low reference) |
| cfg_pos_b | input | IDX_W | Set-B positive channel index |
| cfg_neg_b | input | 1 | Set-B negative choice |
| cfg_scan_mask | input | NUM_CH | Scan mask, bit n enables channel n |
| cfg_alt_en | input | 1 | Alternate A/B sets |
| cfg_scan_en | input | 1 | Scan mode for set A |
| cfg_burst_len | input | CNT_W | Samples per interrupt minus one |
| sel_pos | output | IDX_W | Positive mux select |
| sel_neg | output | 1 | Negative mux select |
| sel_set_b | output | 1 | 1 when set B is active |
| irq_pulse | output | 1 | One-cycle burst-complete pulse |

## Verification
Several properties are checked on every cycle. In scan mode, the selected channel must be an enabled mask bit, or channel 0 when the mask is empty. Set A must hold whenever alternate mode is off, and again right after each interrupt. The phase must toggle on every strobe within a burst. The captured configuration must not move between boundaries, and the interrupt must follow a strobe. The exact order of scanned channels, the wrap-around, how the scan and alternate modes interleave, and the interrupt count per burst length can only be shown by the bench's scenarios. There, a behavioural model predicts every output on every clock.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
   typedef enum logic {
      PH_A = 1'b0,
      PH_B = 1'b1
   } phase_e;

   function automatic phase_e flip_phase(input phase_e p);
      return (p == PH_A) ? PH_B : PH_A;
   endfunction
endpackage

// File: rtl/acs_scan_pick.sv
module acs_scan_pick #(
   parameter int NUM_CH = 16,
   parameter int IDX_W  = 4
) (
   input  logic [NUM_CH-1:0] mask,
   input  logic [IDX_W-1:0]  start,
   output logic [IDX_W-1:0]  pick
);
   logic [NUM_CH-1:0] upper;

   for (genvar i = 0; i < NUM_CH; i++) begin : g_upper
      assign upper[i] = mask[i] && (IDX_W'(i) >= start);
   end

   function automatic logic [IDX_W-1:0] lowest(input logic [NUM_CH-1:0] v);
      logic [IDX_W-1:0] r;
      r = '0;
      for (int k = NUM_CH - 1; k >= 0; k--) begin
         if (v[k]) r = IDX_W'(k);
      end
      return r;
   endfunction

   // first enabled channel at or above start, else wrap to lowest, else 0
   always_comb begin
      if (|upper) pick = lowest(upper);
      else        pick = lowest(mask);
   end
endmodule

// File: rtl/acs_sample_ctr.sv
module acs_sample_ctr #(
   parameter int CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             step,
   input  logic [CNT_W-1:0] limit,
   output logic             last
);
   logic [CNT_W-1:0] cnt_q;

   assign last = (cnt_q == limit);

   always_ff @(posedge clk) begin
      if (rst)       cnt_q <= '0;
      else if (step) cnt_q <= last ? '0 : cnt_q + CNT_W'(1);
   end
endmodule

// File: rtl/adc_chan_seq.sv
module adc_chan_seq
   import adc_seq_pkg::*;
#(
   parameter int NUM_CH = 16,
   parameter int CNT_W  = 4,
   localparam int IDX_W = $clog2(NUM_CH)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              conv_done,
   input  logic [IDX_W-1:0]  cfg_pos_a,
   input  logic              cfg_neg_a,
   input  logic [IDX_W-1:0]  cfg_pos_b,
   input  logic              cfg_neg_b,
   input  logic [NUM_CH-1:0] cfg_scan_mask,
   input  logic              cfg_alt_en,
   input  logic              cfg_scan_en,
   input  logic [CNT_W-1:0]  cfg_burst_len,
   output logic [IDX_W-1:0]  sel_pos,
   output logic              sel_neg,
   output logic              sel_set_b,
   output logic              irq_pulse
);
   if (NUM_CH < 2 || NUM_CH > 64) begin : g_bad_num_ch
      $error("adc_chan_seq: NUM_CH must be within 2..64");
   end
   if (CNT_W < 1 || CNT_W > 8) begin : g_bad_cnt_w
      $error("adc_chan_seq: CNT_W must be within 1..8");
   end

   localparam bit POW2 = (NUM_CH == (1 << IDX_W));

   // captured configuration
   logic [IDX_W-1:0]  pos_a_q, pos_b_q;
   logic              neg_a_q, neg_b_q, alt_q, scan_q;
   logic [NUM_CH-1:0] mask_q;
   logic [CNT_W-1:0]  len_q;

   phase_e            phase_q;
   logic [IDX_W-1:0]  ptr_q;
   logic [IDX_W-1:0]  ptr_next;
   logic [IDX_W-1:0]  scan_ch;
   logic [IDX_W-1:0]  a_pos;
   logic              irq_q;
   logic              last;
   logic              boundary;
   logic              load;

   acs_sample_ctr #(.CNT_W(CNT_W)) i_ctr (
      .clk   (clk),
      .rst   (rst),
      .step  (conv_done),
      .limit (len_q),
      .last  (last)
   );

   acs_scan_pick #(.NUM_CH(NUM_CH), .IDX_W(IDX_W)) i_pick (
      .mask  (mask_q),
      .start (ptr_q),
      .pick  (scan_ch)
   );

   assign boundary = conv_done & last;
   assign load     = rst | boundary;

   if (POW2) begin : g_ptr_wrap_free
      assign ptr_next = scan_ch + IDX_W'(1);
   end else begin : g_ptr_wrap_cmp
      assign ptr_next = (scan_ch == IDX_W'(NUM_CH - 1)) ? '0 : scan_ch + IDX_W'(1);
   end

   always_ff @(posedge clk) begin
      if (load) begin
         pos_a_q <= cfg_pos_a;
         neg_a_q <= cfg_neg_a;
         pos_b_q <= cfg_pos_b;
         neg_b_q <= cfg_neg_b;
         mask_q  <= cfg_scan_mask;
         alt_q   <= cfg_alt_en;
         scan_q  <= cfg_scan_en;
         len_q   <= cfg_burst_len;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         phase_q <= PH_A;
         ptr_q   <= '0;
         irq_q   <= 1'b0;
      end else begin
         irq_q <= boundary;
         if (conv_done) begin
            if (last) begin
               phase_q <= PH_A;
               ptr_q   <= '0;
            end else begin
               if (alt_q) phase_q <= flip_phase(phase_q);
               if (phase_q == PH_A && scan_q) ptr_q <= ptr_next;
            end
         end
      end
   end

   assign a_pos     = scan_q ? scan_ch : pos_a_q;
   assign sel_pos   = (phase_q == PH_B) ? pos_b_q : a_pos;
   assign sel_neg   = (phase_q == PH_B) ? neg_b_q : neg_a_q;
   assign sel_set_b = (phase_q == PH_B);
   assign irq_pulse = irq_q;
endmodule

// File: rtl/acs_seq_checker.sv
module acs_seq_checker #(
   parameter int NUM_CH = 16,
   parameter int CNT_W  = 4,
   parameter int IDX_W  = 4
) (
   input logic              clk,
   input logic              rst,
   input logic              conv_done,
   input logic              irq_pulse,
   input logic              sel_set_b,
   input logic [IDX_W-1:0]  sel_pos,
   input logic [NUM_CH-1:0] mask_q,
   input logic [CNT_W-1:0]  len_q,
   input logic              scan_q,
   input logic              alt_q
);
   AST_IRQ_AFTER_STROBE: assert property (@(posedge clk) disable iff (rst)
      irq_pulse |-> $past(conv_done)); // R8

   AST_IRQ_RESTARTS_A: assert property (@(posedge clk) disable iff (rst)
      irq_pulse |-> !sel_set_b); // R4

   AST_NO_ALT_STAYS_A: assert property (@(posedge clk) disable iff (rst)
      !alt_q |-> !sel_set_b); // R3

   AST_ALT_TOGGLES: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $past(conv_done) && $past(alt_q) && !irq_pulse)
         |-> (sel_set_b != $past(sel_set_b))); // R4

   AST_SCAN_ENABLED_ONLY: assert property (@(posedge clk) disable iff (rst)
      (!sel_set_b && scan_q && (mask_q != '0)) |-> mask_q[sel_pos]); // R5

   AST_EMPTY_MASK_CH0: assert property (@(posedge clk) disable iff (rst)
      (!sel_set_b && scan_q && (mask_q == '0)) |-> (sel_pos == '0)); // R9

   AST_CFG_HELD: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && !irq_pulse) |-> ($stable(mask_q) && $stable(len_q)
                                      && $stable(scan_q) && $stable(alt_q))); // R10
endmodule

bind adc_chan_seq acs_seq_checker #(
   .NUM_CH (NUM_CH),
   .CNT_W  (CNT_W),
   .IDX_W  (IDX_W)
) i_seq_checker (
   .clk       (clk),
   .rst       (rst),
   .conv_done (conv_done),
   .irq_pulse (irq_pulse),
   .sel_set_b (sel_set_b),
   .sel_pos   (sel_pos),
   .mask_q    (mask_q),
   .len_q     (len_q),
   .scan_q    (scan_q),
   .alt_q     (alt_q)
);

// File: tb/test_adc_chan_seq.sv
module test_adc_chan_seq;
   localparam int NUM_CH = 16;
   localparam int CNT_W  = 4;
   localparam int IDX_W  = 4;

   logic              clk = 1'b0;
   logic              rst = 1'b1;
   logic              conv_done = 1'b0;
   logic [IDX_W-1:0]  cfg_pos_a = '0;
   logic              cfg_neg_a = 1'b0;
   logic [IDX_W-1:0]  cfg_pos_b = '0;
   logic              cfg_neg_b = 1'b0;
   logic [NUM_CH-1:0] cfg_scan_mask = '0;
   logic              cfg_alt_en = 1'b0;
   logic              cfg_scan_en = 1'b0;
   logic [CNT_W-1:0]  cfg_burst_len = '0;
   logic [IDX_W-1:0]  sel_pos;
   logic              sel_neg;
   logic              sel_set_b;
   logic              irq_pulse;

   always #2 clk = ~clk;

   adc_chan_seq #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) i_adc_chan_seq (
      .clk(clk), .rst(rst), .conv_done(conv_done),
      .cfg_pos_a(cfg_pos_a), .cfg_neg_a(cfg_neg_a),
      .cfg_pos_b(cfg_pos_b), .cfg_neg_b(cfg_neg_b),
      .cfg_scan_mask(cfg_scan_mask), .cfg_alt_en(cfg_alt_en),
      .cfg_scan_en(cfg_scan_en), .cfg_burst_len(cfg_burst_len),
      .sel_pos(sel_pos), .sel_neg(sel_neg), .sel_set_b(sel_set_b),
      .irq_pulse(irq_pulse)
   );

   int n_checks = 0;
   int n_err    = 0;
   string cur_tag = "R11";
   bit chk_on = 1'b0;
   int irq_seen = 0;
   int max_a_pos = 0;

   // behavioural reference
   int m_pa, m_na, m_pb, m_nb, m_alt, m_scan, m_len;
   int m_list[$];
   int m_idx, m_phase, m_cnt, m_irq;

   task automatic m_load();
      m_list.delete();
      for (int c = 0; c < NUM_CH; c++) if (cfg_scan_mask[c]) m_list.push_back(c);
      m_pa = cfg_pos_a;  m_na = cfg_neg_a;
      m_pb = cfg_pos_b;  m_nb = cfg_neg_b;
      m_alt = cfg_alt_en; m_scan = cfg_scan_en;
      m_len = int'(cfg_burst_len) + 1;
   endtask

   function automatic int exp_pos();
      if (m_phase == 1) return m_pb;
      if (m_scan == 0) return m_pa;
      if (m_list.size() == 0) return 0;
      return m_list[m_idx % m_list.size()];
   endfunction

   always @(posedge clk) begin
      if (rst) begin
         m_load();
         m_phase = 0; m_idx = 0; m_cnt = 0; m_irq = 0;
      end else begin
         m_irq = 0;
         if (conv_done) begin
            m_cnt++;
            if (m_cnt == m_len) begin
               m_load();
               m_cnt = 0; m_phase = 0; m_idx = 0; m_irq = 1;
            end else begin
               if (m_phase == 0) m_idx++;
               if (m_alt != 0) m_phase = 1 - m_phase;
            end
         end
      end
      chk_on <= 1'b1;
   end

   task automatic check(string what, int got, int exp);
      n_checks++;
      if (got != exp) begin
         n_err++;
         $display("FAIL %s %s got=%0d exp=%0d at %0t", cur_tag, what, got, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (chk_on) begin
         check("sel_pos", int'(sel_pos), exp_pos());
         check("sel_neg", int'(sel_neg), (m_phase == 1) ? m_nb : m_na);
         check("sel_set_b", int'(sel_set_b), m_phase);
         check("irq_pulse", int'(irq_pulse), m_irq);
         if (irq_pulse) irq_seen++;
         if (!sel_set_b && int'(sel_pos) > max_a_pos) max_a_pos = int'(sel_pos);
      end
   end

   task automatic do_reset();
      @(negedge clk) rst = 1'b1;
      @(negedge clk) rst = 1'b0;
   endtask

   task automatic strobes(int n, int gap);
      for (int k = 0; k < n; k++) begin
         @(negedge clk) conv_done = 1'b1;
         @(negedge clk) conv_done = 1'b0;
         repeat (gap) @(negedge clk);
      end
   endtask

   task automatic hold_strobe(int n);
      @(negedge clk) conv_done = 1'b1;
      repeat (n) @(negedge clk);
      conv_done = 1'b0;
   endtask

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", n_err, n_checks);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_checks++; n_err++;
      $display("FAIL watchdog expired got=running exp=finished");
      summary();
      $finish;
   end

   initial begin
      // R11: reset state, strobes during reset ignored
      cur_tag = "R11";
      cfg_pos_a = 4'd5; cfg_neg_a = 1'b1; cfg_burst_len = 4'd3;
      conv_done = 1'b1;
      repeat (3) @(negedge clk);
      conv_done = 1'b0;
      rst = 1'b0;
      @(negedge clk);
      check("R11 reset set_b", int'(sel_set_b), 0);
      check("R11 reset irq", int'(irq_pulse), 0);
      check("R11 reset pos", int'(sel_pos), 5);

      // R1/R2/R3: set A only
      cur_tag = "R1/R2/R3";
      cfg_pos_b = 4'd9; cfg_neg_b = 1'b0;
      do_reset();
      strobes(10, 1);

      // R4 with R1/R2 on set B
      cur_tag = "R4";
      cfg_alt_en = 1'b1; cfg_pos_a = 4'd2; cfg_neg_a = 1'b0;
      cfg_pos_b = 4'd14; cfg_neg_b = 1'b1; cfg_burst_len = 4'd4;
      do_reset();
      strobes(15, 0);

      // R5: ascending scan with wrap and restart
      cur_tag = "R5";
      cfg_alt_en = 1'b0; cfg_scan_en = 1'b1;
      cfg_scan_mask = 16'hA422; cfg_burst_len = 4'd6;
      do_reset();
      strobes(21, 2);

      // R6: scan interleaved with set B
      cur_tag = "R6";
      cfg_alt_en = 1'b1; cfg_scan_mask = 16'h8091; cfg_burst_len = 4'd7;
      cfg_pos_b = 4'd3; cfg_neg_b = 1'b1; cfg_neg_a = 1'b1;
      do_reset();
      strobes(24, 1);

      // R7: more channels than samples
      cur_tag = "R7";
      cfg_alt_en = 1'b0; cfg_scan_mask = 16'hFFFF; cfg_burst_len = 4'd2;
      do_reset();
      max_a_pos = 0;
      strobes(12, 0);
      check("R7 highest scanned channel", max_a_pos, 2);

      // R9: empty mask picks channel 0
      cur_tag = "R9";
      cfg_scan_mask = '0; cfg_pos_a = 4'd11; cfg_burst_len = 4'd3;
      do_reset();
      strobes(6, 0);
      check("R9 empty mask pos", int'(sel_pos), 0);

      // R10: mid-burst config change held off until boundary
      cur_tag = "R10";
      cfg_scan_en = 1'b0; cfg_pos_a = 4'd6; cfg_burst_len = 4'd3;
      do_reset();
      strobes(1, 0);
      cfg_pos_a = 4'd13; cfg_burst_len = 4'd0; cfg_alt_en = 1'b1;
      strobes(1, 0);
      check("R10 pos held", int'(sel_pos), 6);
      check("R10 alt held", int'(sel_set_b), 0);
      strobes(2, 0);
      check("R10 pos after boundary", int'(sel_pos), 13);

      // R8: burst length and irq count, back-to-back strobes
      cur_tag = "R8";
      cfg_alt_en = 1'b0; cfg_burst_len = 4'd3;
      do_reset();
      irq_seen = 0;
      hold_strobe(12);
      repeat (2) @(negedge clk);
      check("R8 irq count len4", irq_seen, 3);
      cfg_burst_len = 4'd0;
      do_reset();
      irq_seen = 0;
      hold_strobe(5);
      repeat (2) @(negedge clk);
      check("R8 irq count len1", irq_seen, 5);
      cfg_burst_len = 4'd15; cfg_alt_en = 1'b1;
      do_reset();
      irq_seen = 0;
      strobes(32, 0);
      repeat (2) @(negedge clk);
      check("R8 irq count len16", irq_seen, 2);

      summary();
      $finish;
   end
endmodule